// File: doc/BRIEF.md
# Transmit DMA Port Transfer Engine

This block drains queued frames from a shared frame buffer memory, 64 bits wide, into the transmit FIFOs of several output ports. One read engine is shared by all ports. Each cycle it picks the next port in a round-robin rotation that has a frame in progress and room in its FIFO. It reads one word for that port and writes the word, with a byte-valid count, into that port's FIFO on the following cycle. A frame therefore moves eight bytes per turn, and the last turn carries only the bytes that remain.

A frame is handed to a port with a start word address, a byte length, a frame-control-block tag and a destination count. When a port writes its end-of-frame word, the engine decrements the tag's destination counter. The port that takes the counter to zero requests release of the control block. Every other port of a multicast frame simply goes idle. Release requests from different ports wait at a rotating-priority arbiter, which grants at most one per cycle whenever the consumer signals it can accept.

Top module: `txdma_engine`

## Requirements
- R1: Each FIFO write carries a byte count on `fifo_bytes` (value 1 to 8). Every word of a frame except the last carries 8. The last word carries the frame length minus eight times the number of earlier words, and `fifo_eof` is high on that word only.
- R2: A read issued with `mem_rd_en` is written, one cycle later, into the FIFO of the port it was issued for. The data is `mem_rd_data` exactly as presented. Word k of a frame comes from the start address plus k. At most one bit of `fifo_wr` is high in any cycle.
- R3: A frame loaded with `ld_dests` = 1 raises exactly one release request after its end-of-frame write. That request carries the frame's tag on `rel_fcb` and the port on `rel_port`.
- R4: Ports that are eligible at the same time are served in ascending circular port order. A port is never served in two consecutive cycles, so a port working alone receives a word at most every second cycle.
- R5: No read is issued for a port whose `fifo_space_ok` bit is low. That port keeps its frame and resumes when the bit returns high.
- R6: A load is accepted only when the addressed port is idle (`port_busy` bit low) and `ld_len` is nonzero. Any other load is ignored and leaves the port's frame and state unchanged.
- R7: A load with nonzero `ld_dests` sets the tag's destination counter to that value. A load with `ld_dests` = 0 joins the count already set. Only the port whose end-of-frame brings the counter to zero raises a release, so a multicast frame yields exactly one release, after its last destination finishes.
- R8: A pending release holds `rel_valid` high while `rel_ready` is low, with the port still busy. Grants occur only when both are high, at most one per cycle, in rotating port order. The granted port becomes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Frame load strobe |
| ld_port | input | PORT_W | Port that receives the frame |
| ld_addr | input | ADDR_W | Start word address in frame memory |
| ld_len | input | LEN_W | Frame length in bytes |
| ld_fcb | input | FCB_W | Frame-control-block tag |
| ld_dests | input | DCNT_W | Destination count, 0 joins an existing count |
| port_busy | output | NUM_PORTS | Port holds a frame or a pending release |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read word address |
| mem_rd_data | input | 64 | Read data, valid one cycle after the request |
| fifo_space_ok | input | NUM_PORTS | FIFO can accept one more word |
| fifo_wr | output | NUM_PORTS | One-hot FIFO write strobe |
| fifo_data | output | 64 | FIFO write data |
| fifo_bytes | output | 4 | Valid bytes in the written word |
| fifo_eof | output | 1 | Written word ends the frame |
| rel_ready | input | 1 | Release consumer accepts a request |
| rel_valid | output | 1 | Release request pending |
| rel_fcb | output | FCB_W | Tag to release |
| rel_port | output | PORT_W | Port whose end-of-frame triggered the release |

## Verification
The hardest case to reach from the ports is several release requests waiting at once. End-of-frame writes are serialized to one per cycle, and a free consumer drains each request in the cycle after it appears, so contention never forms on its own. The bench holds `rel_ready` low while three ports finish short frames, which leaves three requests pending together. It then raises `rel_ready` and checks that the grants come in three consecutive cycles and in circular port order. A second hard case is a port that is starved because its FIFO is full while its neighbours keep moving. The bench holds that port's space bit low across a long window and then releases it.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

   localparam int WORD_BYTES = 8;
   localparam int WORD_BITS  = 64;
   localparam int BCNT_W     = 4;

   typedef enum logic [1:0] {
      PS_IDLE   = 2'd0,
      PS_ACTIVE = 2'd1,
      PS_DRAIN  = 2'd2,
      PS_REL    = 2'd3
   } port_state_e;

endpackage

// File: rtl/txdma_rr_pick.sv
module txdma_rr_pick #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          adv,
   output logic          any,
   output logic [IW-1:0] idx
);

   logic [IW-1:0] ptr;
   logic [IW-1:0] ptr_nxt;
   int            cand;

   always_comb begin
      any  = 1'b0;
      idx  = ptr;
      cand = 0;
      for (int k = 0; k < N; k++) begin
         cand = int'(ptr) + k;
         if (cand >= N) cand = cand - N;
         if (!any && req[cand]) begin
            any = 1'b1;
            idx = IW'(cand);
         end
      end
   end

   generate
      if ((N & (N - 1)) == 0) begin : g_pow2
         always_comb ptr_nxt = idx + IW'(1);
      end else begin : g_mod
         always_comb ptr_nxt = (int'(idx) == N - 1) ? '0 : idx + IW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          ptr <= '0;
      else if (adv && any) ptr <= ptr_nxt;
   end

endmodule

// File: rtl/txdma_port_ctx.sv
module txdma_port_ctx
   import txdma_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int LEN_W  = 11,
   parameter int FCB_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [LEN_W-1:0]  ld_len,
   input  logic [FCB_W-1:0]  ld_fcb,
   input  logic              issue,
   input  logic              wb_eof,
   input  logic              wb_rel,
   input  logic              grant,
   output port_state_e       state,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [FCB_W-1:0]  cur_fcb,
   output logic [BCNT_W-1:0] iss_bytes,
   output logic              iss_last
);

   logic [LEN_W-1:0] remain;

   always_comb begin
      iss_last  = (remain <= LEN_W'(WORD_BYTES));
      iss_bytes = iss_last ? remain[BCNT_W-1:0] : BCNT_W'(WORD_BYTES);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= PS_IDLE;
         cur_addr <= '0;
         cur_fcb  <= '0;
         remain   <= '0;
      end else begin
         case (state)
            PS_IDLE: begin
               if (ld) begin
                  state    <= PS_ACTIVE;
                  cur_addr <= ld_addr;
                  cur_fcb  <= ld_fcb;
                  remain   <= ld_len;
               end
            end
            PS_ACTIVE: begin
               if (issue) begin
                  cur_addr <= cur_addr + ADDR_W'(1);
                  remain   <= remain - LEN_W'(iss_bytes);
                  if (iss_last) state <= PS_DRAIN;
               end
            end
            PS_DRAIN: begin
               if (wb_eof) state <= wb_rel ? PS_REL : PS_IDLE;
            end
            PS_REL: begin
               if (grant) state <= PS_IDLE;
            end
            default: state <= PS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/txdma_dest_cnt.sv
module txdma_dest_cnt #(
   parameter int FCB_W  = 4,
   parameter int DCNT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [FCB_W-1:0]  set_fcb,
   input  logic [DCNT_W-1:0] set_cnt,
   input  logic              dec_en,
   input  logic [FCB_W-1:0]  dec_fcb,
   output logic              dec_last
);

   localparam int DEPTH = 1 << FCB_W;

   logic [DCNT_W-1:0] cnt [DEPTH];

   assign dec_last = (cnt[dec_fcb] <= DCNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cnt[i] <= '0;
      end else begin
         if (dec_en && cnt[dec_fcb] != '0) cnt[dec_fcb] <= cnt[dec_fcb] - DCNT_W'(1);
         if (set_en) cnt[set_fcb] <= set_cnt;
      end
   end

endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
   import txdma_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int ADDR_W    = 12,
   parameter int LEN_W     = 11,
   parameter int FCB_W     = 4,
   parameter int DCNT_W    = 3,
   parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ld_valid,
   input  logic [PORT_W-1:0]     ld_port,
   input  logic [ADDR_W-1:0]     ld_addr,
   input  logic [LEN_W-1:0]      ld_len,
   input  logic [FCB_W-1:0]      ld_fcb,
   input  logic [DCNT_W-1:0]     ld_dests,
   output logic [NUM_PORTS-1:0]  port_busy,
   output logic                  mem_rd_en,
   output logic [ADDR_W-1:0]     mem_rd_addr,
   input  logic [WORD_BITS-1:0]  mem_rd_data,
   input  logic [NUM_PORTS-1:0]  fifo_space_ok,
   output logic [NUM_PORTS-1:0]  fifo_wr,
   output logic [WORD_BITS-1:0]  fifo_data,
   output logic [BCNT_W-1:0]     fifo_bytes,
   output logic                  fifo_eof,
   input  logic                  rel_ready,
   output logic                  rel_valid,
   output logic [FCB_W-1:0]      rel_fcb,
   output logic [PORT_W-1:0]     rel_port
);

   initial begin
      assert (NUM_PORTS >= 2) else $error("txdma_engine: NUM_PORTS must be at least 2");
      assert (LEN_W >= BCNT_W) else $error("txdma_engine: LEN_W too narrow");
      assert (DCNT_W >= 1)     else $error("txdma_engine: DCNT_W must be positive");
      assert ((1 << PORT_W) >= NUM_PORTS) else $error("txdma_engine: PORT_W too narrow");
   end

   port_state_e       st_a    [NUM_PORTS];
   logic [ADDR_W-1:0] addr_a  [NUM_PORTS];
   logic [FCB_W-1:0]  fcb_a   [NUM_PORTS];
   logic [BCNT_W-1:0] bytes_a [NUM_PORTS];
   logic [NUM_PORTS-1:0] last_a;

   logic [NUM_PORTS-1:0] elig, rel_req, ld_hit, iss_hit, eof_hit, gnt_hit;
   logic                 ld_ok;
   logic                 iss_any;
   logic [PORT_W-1:0]    iss_idx;
   logic                 rel_any;
   logic [PORT_W-1:0]    rel_idx;
   logic                 dec_last;

   // in-flight word: issued last cycle, written this cycle
   logic                 fl_v;
   logic [PORT_W-1:0]    fl_port;
   logic [BCNT_W-1:0]    fl_bytes;
   logic                 fl_last;
   logic [FCB_W-1:0]     fl_fcb;

   assign ld_ok = ld_valid && (ld_len != '0) && (int'(ld_port) < NUM_PORTS)
                  && !port_busy[ld_port];

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         assign ld_hit[p]  = ld_ok && (ld_port == PORT_W'(p));
         assign iss_hit[p] = iss_any && (iss_idx == PORT_W'(p));
         assign eof_hit[p] = fl_v && fl_last && (fl_port == PORT_W'(p));
         assign gnt_hit[p] = rel_any && rel_ready && (rel_idx == PORT_W'(p));
         assign elig[p]    = (st_a[p] == PS_ACTIVE) && fifo_space_ok[p]
                             && !(fl_v && fl_port == PORT_W'(p));
         assign rel_req[p] = (st_a[p] == PS_REL);
         assign port_busy[p] = (st_a[p] != PS_IDLE);
         assign fifo_wr[p] = fl_v && (fl_port == PORT_W'(p));

         txdma_port_ctx #(
            .ADDR_W (ADDR_W),
            .LEN_W  (LEN_W),
            .FCB_W  (FCB_W)
         ) u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld        (ld_hit[p]),
            .ld_addr   (ld_addr),
            .ld_len    (ld_len),
            .ld_fcb    (ld_fcb),
            .issue     (iss_hit[p]),
            .wb_eof    (eof_hit[p]),
            .wb_rel    (dec_last),
            .grant     (gnt_hit[p]),
            .state     (st_a[p]),
            .cur_addr  (addr_a[p]),
            .cur_fcb   (fcb_a[p]),
            .iss_bytes (bytes_a[p]),
            .iss_last  (last_a[p])
         );
      end
   endgenerate

   txdma_rr_pick #(.N(NUM_PORTS), .IW(PORT_W)) u_iss_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (elig),
      .adv   (iss_any),
      .any   (iss_any),
      .idx   (iss_idx)
   );

   txdma_rr_pick #(.N(NUM_PORTS), .IW(PORT_W)) u_rel_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (rel_req),
      .adv   (rel_ready),
      .any   (rel_any),
      .idx   (rel_idx)
   );

   txdma_dest_cnt #(.FCB_W(FCB_W), .DCNT_W(DCNT_W)) u_dest (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (ld_ok && (ld_dests != '0)),
      .set_fcb  (ld_fcb),
      .set_cnt  (ld_dests),
      .dec_en   (fl_v && fl_last),
      .dec_fcb  (fl_fcb),
      .dec_last (dec_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fl_v     <= 1'b0;
         fl_port  <= '0;
         fl_bytes <= '0;
         fl_last  <= 1'b0;
         fl_fcb   <= '0;
      end else begin
         fl_v <= iss_any;
         if (iss_any) begin
            fl_port  <= iss_idx;
            fl_bytes <= bytes_a[iss_idx];
            fl_last  <= last_a[iss_idx];
            fl_fcb   <= fcb_a[iss_idx];
         end
      end
   end

   assign mem_rd_en   = iss_any;
   assign mem_rd_addr = addr_a[iss_idx];
   assign fifo_data   = mem_rd_data;
   assign fifo_bytes  = fl_v ? fl_bytes : '0;
   assign fifo_eof    = fl_v && fl_last;
   assign rel_valid   = rel_any;
   assign rel_fcb     = fcb_a[rel_idx];
   assign rel_port    = rel_idx;

endmodule

// File: rtl/txdma_engine_chk.sv
module txdma_engine_chk #(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 mem_rd_en,
   input logic [PORT_W-1:0]    iss_idx,
   input logic [NUM_PORTS-1:0] fifo_space_ok,
   input logic [NUM_PORTS-1:0] fifo_wr,
   input logic [3:0]           fifo_bytes,
   input logic                 fifo_eof,
   input logic                 rel_valid,
   input logic                 rel_ready,
   input logic [PORT_W-1:0]    rel_port,
   input logic [NUM_PORTS-1:0] port_busy
);

   AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fifo_wr)); // R2

   AST_READ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> (fifo_wr != '0)); // R2

   AST_BYTES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr != '0) |-> (fifo_bytes >= 4'd1 && fifo_bytes <= 4'd8)); // R1

   AST_SHORT_IS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      ((fifo_wr != '0) && fifo_bytes != 4'd8) |-> fifo_eof); // R1

   AST_SPACE_HONORED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> fifo_space_ok[iss_idx]); // R5

   AST_NO_REPEAT_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |-> (iss_idx != $past(iss_idx))); // R4

   AST_REL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && !rel_ready) |=> rel_valid); // R8

   AST_REL_PORT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> port_busy[rel_port]); // R8

endmodule

bind txdma_engine txdma_engine_chk #(
   .NUM_PORTS (NUM_PORTS),
   .PORT_W    (PORT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mem_rd_en     (mem_rd_en),
   .iss_idx       (iss_idx),
   .fifo_space_ok (fifo_space_ok),
   .fifo_wr       (fifo_wr),
   .fifo_bytes    (fifo_bytes),
   .fifo_eof      (fifo_eof),
   .rel_valid     (rel_valid),
   .rel_ready     (rel_ready),
   .rel_port      (rel_port),
   .port_busy     (port_busy)
);

// File: tb/txdma_engine_test.sv
module txdma_engine_test;

   localparam int NP = 4;
   localparam int AW = 12;
   localparam int LW = 11;
   localparam int FW = 4;
   localparam int DW = 3;
   localparam int PW = 2;

   // vector table: port, start address, length, tag, expected words, expected last-word bytes
   localparam int NV = 6;
   localparam int TV_PORT  [NV] = '{0, 1, 2, 3, 1, 2};
   localparam int TV_ADDR  [NV] = '{16, 40, 80, 120, 300, 500};
   localparam int TV_LEN   [NV] = '{1, 8, 9, 16, 23, 61};
   localparam int TV_FCB   [NV] = '{2, 3, 4, 5, 6, 7};
   localparam int TV_WORDS [NV] = '{1, 1, 2, 2, 3, 8};
   localparam int TV_LASTB [NV] = '{1, 8, 1, 8, 7, 5};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_valid = 1'b0;
   logic [PW-1:0] ld_port = '0;
   logic [AW-1:0] ld_addr = '0;
   logic [LW-1:0] ld_len = '0;
   logic [FW-1:0] ld_fcb = '0;
   logic [DW-1:0] ld_dests = '0;
   logic [NP-1:0] port_busy;
   logic          mem_rd_en;
   logic [AW-1:0] mem_rd_addr;
   logic [63:0]   mem_rd_data = '0;
   logic [NP-1:0] fifo_space_ok = '1;
   logic [NP-1:0] fifo_wr;
   logic [63:0]   fifo_data;
   logic [3:0]    fifo_bytes;
   logic          fifo_eof;
   logic          rel_ready = 1'b1;
   logic          rel_valid;
   logic [FW-1:0] rel_fcb;
   logic [PW-1:0] rel_port;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   txdma_engine #(.NUM_PORTS(NP), .ADDR_W(AW), .LEN_W(LW), .FCB_W(FW), .DCNT_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_port(ld_port), .ld_addr(ld_addr),
      .ld_len(ld_len), .ld_fcb(ld_fcb), .ld_dests(ld_dests), .port_busy(port_busy),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .fifo_space_ok(fifo_space_ok), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
      .fifo_bytes(fifo_bytes), .fifo_eof(fifo_eof), .rel_ready(rel_ready),
      .rel_valid(rel_valid), .rel_fcb(rel_fcb), .rel_port(rel_port));

   function automatic logic [63:0] mw(input logic [AW-1:0] a);
      return {a, ~a, 8'hC3, a ^ 12'h96A, 4'h7, a, 4'hE};
   endfunction

   // memory model: one cycle read latency
   always @(posedge clk) if (mem_rd_en) mem_rd_data <= mw(mem_rd_addr);

   // event logs, sampled at the falling edge
   int          cyc = 0;
   int          wn = 0, rn = 0;
   int          wport [512];
   logic [63:0] wdata [512];
   int          wbytes [512];
   bit          weof [512];
   int          wcyc [512];
   int          rport [64];
   int          rfcb [64];
   int          rcyc [64];

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (fifo_wr != '0 && wn < 512) begin
            for (int p = 0; p < NP; p++) if (fifo_wr[p]) wport[wn] = p;
            wdata[wn] = fifo_data;
            wbytes[wn] = int'(fifo_bytes);
            weof[wn] = fifo_eof;
            wcyc[wn] = cyc;
            wn++;
         end
         if (rel_valid && rel_ready && rn < 64) begin
            rport[rn] = int'(rel_port);
            rfcb[rn] = int'(rel_fcb);
            rcyc[rn] = cyc;
            rn++;
         end
      end
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clear_logs();
      @(negedge clk);
      wn = 0;
      rn = 0;
      #1;
   endtask

   task automatic load(input int p, input int a, input int len, input int fcb, input int dests);
      ld_valid = 1'b1;
      ld_port = PW'(p);
      ld_addr = AW'(a);
      ld_len = LW'(len);
      ld_fcb = FW'(fcb);
      ld_dests = DW'(dests);
      tick(1);
      ld_valid = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (port_busy != '0 && n < 3000) begin
         tick(1);
         n++;
      end
      tick(2);
   endtask

   task automatic verify_frame(input int p, input int a, input int words, input int lastb,
                               input int fcb);
      int n = 0, bad = 0, eofc = 0, rc = 0, rf = -1, rt = 0, expb;
      for (int i = 0; i < wn; i++) begin
         if (wport[i] == p) begin
            expb = (n == words - 1) ? lastb : 8;
            if (wdata[i] != mw(AW'(a + n)) || wbytes[i] != expb || weof[i] != (n == words - 1))
               bad++;
            if (weof[i]) eofc = wcyc[i];
            n++;
         end
      end
      for (int i = 0; i < rn; i++) begin
         if (rport[i] == p) begin
            rc++;
            rf = rfcb[i];
            rt = rcyc[i];
         end
      end
      check(n == words, "R1 word count of frame", n, words);
      check(bad == 0, "R2 word data, byte count or eof mismatches", bad, 0);
      check(rc == 1, "R3 release count", rc, 1);
      check(rf == fcb, "R3 release tag", rf, fcb);
      check(rt > eofc, "R3 release cycle after eof cycle", rt, eofc + 1);
   endtask

   initial begin
      int bad, gap, cnt1, desc;
      tick(3);
      check(port_busy == '0, "R6 reset port_busy", int'(port_busy), 0);
      check(fifo_wr == '0 && !mem_rd_en, "R2 reset no read or write", int'(fifo_wr), 0);
      check(!rel_valid, "R8 reset rel_valid", int'(rel_valid), 0);
      rst_n = 1'b1;
      tick(2);

      // table walk: R1 R2 R3, plus single-port spacing R4
      for (int t = 0; t < NV; t++) begin
         clear_logs();
         load(TV_PORT[t], TV_ADDR[t], TV_LEN[t], TV_FCB[t], 1);
         wait_idle();
         verify_frame(TV_PORT[t], TV_ADDR[t], TV_WORDS[t], TV_LASTB[t], TV_FCB[t]);
         if (TV_WORDS[t] > 1) begin
            gap = 99;
            for (int i = 1; i < wn; i++) if (wcyc[i] - wcyc[i-1] < gap) gap = wcyc[i] - wcyc[i-1];
            check(gap >= 2, "R4 lone port spacing between writes", gap, 2);
         end
      end

      // R4 rotation among four eligible ports
      clear_logs();
      fifo_space_ok = '0;
      for (int p = 0; p < NP; p++) load(p, 1000 + 64 * p, 24, 8 + p, 1);
      fifo_space_ok = '1;
      wait_idle();
      bad = 0;
      for (int i = 1; i < wn; i++) if (wport[i] != (wport[i-1] + 1) % NP) bad++;
      check(wn == 12, "R4 total writes in rotation", wn, 12);
      check(bad == 0, "R4 writes out of circular order", bad, 0);
      for (int p = 0; p < NP; p++) verify_frame(p, 1000 + 64 * p, 3, 8, 8 + p);

      // R5 blocked FIFO skipped, then resumes
      clear_logs();
      fifo_space_ok = 4'b1101;
      load(0, 2000, 16, 1, 1);
      load(1, 2100, 16, 2, 1);
      load(2, 2200, 16, 3, 1);
      tick(40);
      cnt1 = 0;
      for (int i = 0; i < wn; i++) if (wport[i] == 1) cnt1++;
      check(cnt1 == 0, "R5 writes to port with no space", cnt1, 0);
      check(port_busy == 4'b0010, "R5 only blocked port still busy", int'(port_busy), 2);
      fifo_space_ok = '1;
      wait_idle();
      verify_frame(1, 2100, 2, 8, 2);

      // R6 loads to a busy port and zero-length loads are ignored
      clear_logs();
      load(3, 256, 40, 12, 1);
      load(3, 512, 8, 13, 1);
      load(2, 600, 0, 14, 1);
      check(port_busy[2] == 1'b0, "R6 zero-length load left port idle", int'(port_busy[2]), 0);
      wait_idle();
      verify_frame(3, 256, 5, 8, 12);
      cnt1 = 0;
      for (int i = 0; i < wn; i++) if (wport[i] == 2) cnt1++;
      check(cnt1 == 0, "R6 writes from ignored zero-length load", cnt1, 0);
      check(rn == 1, "R6 releases after ignored loads", rn, 1);

      // R7 multicast: three destinations, one release after the last one
      clear_logs();
      load(0, 3000, 8, 9, 3);
      load(1, 3000, 24, 9, 0);
      load(2, 3000, 40, 9, 0);
      while (port_busy[0]) tick(1);
      tick(1);
      check(rn == 0, "R7 no release after first destination", rn, 0);
      wait_idle();
      gap = 0;
      for (int i = 0; i < wn; i++) if (weof[i] && wcyc[i] > gap) gap = wcyc[i];
      check(rn == 1, "R7 multicast release count", rn, 1);
      check(rfcb[0] == 9, "R7 multicast release tag", rfcb[0], 9);
      check(rport[0] == 2, "R7 release from last finishing port", rport[0], 2);
      check(rcyc[0] > gap, "R7 release after last eof", rcyc[0], gap + 1);

      // R8 several releases pending while the consumer stalls
      clear_logs();
      rel_ready = 1'b0;
      load(0, 3500, 8, 10, 1);
      load(1, 3510, 8, 11, 1);
      load(3, 3530, 8, 13, 1);
      tick(20);
      check(rel_valid == 1'b1, "R8 rel_valid held while stalled", int'(rel_valid), 1);
      check(port_busy == 4'b1011, "R8 ports held busy while pending", int'(port_busy), 11);
      check(rn == 0, "R8 no grants while stalled", rn, 0);
      rel_ready = 1'b1;
      tick(6);
      check(rn == 3, "R8 grant count", rn, 3);
      bad = 0;
      desc = 0;
      for (int k = 0; k < 3 && rn == 3; k++) begin
         if (rport[(k + 1) % 3] < rport[k]) desc++;
         if (k < 2 && rcyc[k + 1] != rcyc[k] + 1) bad++;
      end
      check(desc == 1, "R8 grants in circular port order", desc, 1);
      check(bad == 0, "R8 grants one per consecutive cycle", bad, 0);
      check(port_busy == '0, "R8 granted ports idle", int'(port_busy), 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R4 watchdog expired: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule